// File: doc/BRIEF.md
# Edge-Triggered Bit-Slip Word Aligner

This block sits behind an 8-bit deserializer and moves the word boundary of the parallel receive stream one bit at a time. A separate alignment controller watches the output and raises a slip request when the framing looks wrong. Each rising edge of that request adds one bit of delay. The new bit enters at the most significant end of the output word, and the rest of the word moves toward the least significant end. The block keeps the previous raw word, so the output can be taken from any 8-bit window of the last two received words. The slip position wraps around after eight slips.

Every cycle, the block compares the two most recent output words with a 16-bit alignment pattern supplied on an input port. When they match, it raises a one-cycle indication in the same cycle as the second of the two words. The controller can use this indication to stop slipping. The datapath supports only the 8-bit interface width.

Top module: `bitslip_aligner`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its slip position, its raw-word history and its request edge detector, and drives `word_out` = 8'h00 and `pat_hit` = 0.
- R2: With no slip since reset, `word_out` equals the value `rx_word` had two clock edges earlier.
- R3: A clock edge that samples `slip_req` high after sampling it low at the previous edge advances the slip position by exactly one. The new position applies to the word produced at the next edge.
- R4: Holding `slip_req` high for any number of cycles gives only the single slip from its rising edge.
- R5: With slip position k, the word registered at an edge is bits [k+7:k] of {current `rx_word`, previous `rx_word`}. The previous word is in bits [7:0], so each slip fills the MSB from the newer word.
- R6: The slip position counts modulo 8. After eight slips the window is again the previous raw word.
- R7: `pat_hit` is high in the cycle where {`word_out`, previous `word_out`} equals `align_pat` (later word in bits [15:8], earlier word in bits [7:0]). It is high on every such cycle and low otherwise.
- R8: With 8'hF0 received repeatedly, successive slips give 8'h78, 8'h3C, 8'h1E and 8'h0F. With `align_pat` = 16'h0F1E, `pat_hit` rises exactly once, together with the 8'h0F word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_word | input | 8 | Raw parallel word from the deserializer |
| slip_req | input | 1 | Slip request; each rising edge slips one bit |
| align_pat | input | 16 | Alignment pattern, later word in the high byte |
| word_out | output | 8 | Realigned output word |
| pat_hit | output | 1 | One cycle per match of the last two output words with the pattern |

## Verification
The bench builds the block with its default 8-bit word width. At that width the 3-bit slip position is small enough to step through all eight windows and back to zero within a short run. This checks both the window selection at each position and the wrap. The same build covers the request held high, the all-F0 framing example with its single match, and arbitrary data under irregular slip pulses.

// File: rtl/bitslip_aligner.sv
module bitslip_aligner #(
  parameter int DW = 8,
  localparam int SW = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   rx_word,
  input  logic            slip_req,
  input  logic [2*DW-1:0] align_pat,
  output logic [DW-1:0]   word_out,
  output logic            pat_hit
);

  logic [DW-1:0] hist_q;
  logic [SW-1:0] slip_q;
  logic          req_q;

  wire            slip_edge = slip_req & ~req_q;
  wire [2*DW-1:0] pair      = {rx_word, hist_q};
  wire [DW-1:0]   win       = DW'(pair >> slip_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q   <= '0;
      slip_q   <= '0;
      req_q    <= 1'b0;
      word_out <= '0;
      pat_hit  <= 1'b0;
    end else begin
      hist_q   <= rx_word;
      req_q    <= slip_req;
      if (slip_edge) slip_q <= slip_q + 1'b1;
      word_out <= win;
      pat_hit  <= ({win, word_out} == align_pat);
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (slip_q == '0 && word_out == '0 && !pat_hit && !req_q));

  // R3
  slip_step_chk: assert property (@(posedge clk) disable iff (rst)
    (slip_req && !req_q) |=> slip_q == SW'($past(slip_q) + 1));

  // R4
  slip_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(slip_req && !req_q) |=> $stable(slip_q));

  // R7
  hit_match_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pat_hit == ({word_out, $past(word_out)} == $past(align_pat)));

endmodule

// File: tb/tb_bitslip_aligner.sv
module tb_bitslip_aligner;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  rx_word = '0;
  logic        slip_req = 1'b0;
  logic [15:0] align_pat = 16'hA5C3;
  logic [7:0]  word_out;
  logic        pat_hit;

  always #5 clk = ~clk;

  bitslip_aligner dut (.clk(clk), .rst(rst), .rx_word(rx_word), .slip_req(slip_req),
                       .align_pat(align_pat), .word_out(word_out), .pat_hit(pat_hit));

  typedef struct { logic [7:0] w; logic h; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0, hits_seen = 0;
  bit done = 0;

  logic [7:0] m_hist, m_out;
  logic [2:0] m_k;
  logic       m_req;

  task automatic model_clear();
    m_hist = '0; m_out = '0; m_k = '0; m_req = 1'b0;
  endtask

  task automatic step(input logic [7:0] d, input logic r, input string tag);
    logic [15:0] p;
    exp_t e;
    rx_word = d; slip_req = r;
    p = {d, m_hist};
    e.w = p[m_k +: 8];
    e.h = ({e.w, m_out} == align_pat);
    e.tag = tag;
    q.push_back(e);
    if (r && !m_req) m_k = m_k + 3'd1;
    m_hist = d; m_req = r; m_out = e.w;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [15:0] pat);
    while (q.size() > 0) @(negedge clk);
    rst = 1'b1; rx_word = '0; slip_req = 1'b0; align_pat = pat;
    repeat (2) @(negedge clk);
    checks++;
    if (word_out !== 8'h00 || pat_hit !== 1'b0) begin
      fails++;
      $display("FAIL R1: word_out=%h pat_hit=%b expected 00 0", word_out, pat_hit);
    end
    model_clear();
    hits_seen = 0;
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    #2;
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pat_hit === 1'b1) hits_seen++;
      if (word_out !== e.w || pat_hit !== e.h) begin
        fails++;
        $display("FAIL %s: word_out=%h pat_hit=%b expected %h %b", e.tag, word_out, pat_hit, e.w, e.h);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    model_clear();
    @(negedge clk);
    do_reset(16'hA5C3);

    // R2: no slips, two-cycle delay
    for (int i = 0; i < 12; i++) step(8'(i * 37 + 5), 1'b0, "R2");

    // R3 / R5: irregular slip pulses over varied data
    for (int i = 0; i < 40; i++)
      step(8'(i * 91 + 17) ^ 8'(i << 3), (i % 5 == 1) || (i % 7 == 3), (i < 20) ? "R3" : "R5");

    // R4: request held high
    for (int i = 0; i < 15; i++) step(8'(i * 13 + 200), 1'b1, "R4");
    for (int i = 0; i < 5; i++) step(8'(i * 13 + 100), 1'b0, "R4");

    // R6: eight slips return to the zero window
    do_reset(16'hA5C3);
    for (int s = 0; s < 8; s++) begin
      step(8'(s * 29 + 3), 1'b1, "R6");
      step(8'(s * 29 + 4), 1'b0, "R6");
    end
    for (int i = 0; i < 10; i++) step(8'(i * 53 + 9), 1'b0, "R6");

    // R8 / R7: framing example
    do_reset(16'h0F1E);
    for (int i = 0; i < 4; i++) step(8'hF0, 1'b0, "R8");
    for (int s = 0; s < 4; s++) begin
      step(8'hF0, 1'b1, "R8");
      for (int i = 0; i < 3; i++) step(8'hF0, 1'b0, "R8");
    end
    for (int i = 0; i < 6; i++) step(8'hF0, 1'b0, "R8");
    while (q.size() > 0) @(negedge clk);
    checks++;
    if (hits_seen != 1 || word_out !== 8'h0F) begin
      fails++;
      $display("FAIL R7: hits=%0d word_out=%h expected 1 0f", hits_seen, word_out);
    end

    // R7: repeated match on every cycle it holds
    do_reset(16'h5555);
    for (int i = 0; i < 8; i++) step(8'h55, 1'b0, "R7");
    while (q.size() > 0) @(negedge clk);
    checks++;
    if (hits_seen != 6) begin
      fails++;
      $display("FAIL R7: hits=%0d expected 6", hits_seen);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule